// File: doc/BRIEF.md
# Condition Flag Register and Branch Decision Unit

This block keeps the four status bits of a processor core: negative, zero, signed overflow and carry. An arithmetic, compare or test instruction that may change the status asserts a full-update enable, and all four bits take the values the ALU reports. A shift asserts a carry-only enable, and only the carry bit changes. Any other instruction leaves the bits as they were.

The same block decides whether a conditional branch is taken. A 4-bit condition code selects one of sixteen tests on the stored bits. The tests include always and never, equality, signed and unsigned ordering, and tests of the carry, sign and overflow bits alone. When the branch strobe is high, the decision is registered and appears one cycle later. The test reads the stored bits as they were before any update made in the same cycle. Branch target arithmetic and pipeline flushing belong to other blocks.

The asynchronous active-low reset is released in step with the clock through a two-stage synchroniser. The block therefore responds to inputs starting two rising edges after `rst_n` goes high.

Top module: `cflag_top`

## Requirements
- R1: While reset is active, `flags` reads 4'b0000 and `taken` reads 0.
- R2: When `upd_all` is high at a rising edge, `flags` equals `alu_flags` after that edge. Both vectors use bit 3 = negative, bit 2 = zero, bit 1 = overflow and bit 0 = carry.
- R3: When `upd_carry` is high and `upd_all` is low at an edge, `flags[0]` takes `alu_flags[0]` and `flags[3:1]` keep their values.
- R4: When both `upd_all` and `upd_carry` are low, `flags` keeps its value whatever `alu_flags` holds.
- R5: `taken` is registered. After an edge where `br_valid` was high it shows the decision for `br_cond`. After an edge where `br_valid` was low it is 0, whatever `br_cond` holds.
- R6: Code 0 (always) gives 1 and code 1 (never) gives 0 for every flag value.
- R7: Code 2 (equal) gives the zero bit and code 3 (not equal) gives its inverse.
- R8: Code 4 (signed greater) gives !Z && N==V. Code 5 (signed less-or-equal) gives Z || N!=V. Code 6 (signed greater-or-equal) gives N==V. Code 7 (signed less) gives N!=V.
- R9: Code 8 (unsigned greater) gives !C && !Z and code 9 (unsigned less-or-equal) gives C || Z. Code 10 (carry clear) gives !C and code 11 (carry set) gives C.
- R10: Code 12 (positive) gives !N and code 13 (negative) gives N. Code 14 (overflow clear) gives !V and code 15 (overflow set) gives V.
- R11: A branch sampled in the same cycle as a flag update is decided on the flag values from before that update.
- R12: For each even code k, code k+1 gives exactly the inverse of code k on the same flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| alu_flags | input | 4 | ALU status {N, Z, V, C} of the current instruction |
| upd_all | input | 1 | Load all four flags from `alu_flags` |
| upd_carry | input | 1 | Load only the carry flag (shift) |
| br_valid | input | 1 | A conditional branch is being decided this cycle |
| br_cond | input | 4 | Condition code of the branch |
| flags | output | 4 | Stored flags {N, Z, V, C} |
| taken | output | 1 | Registered branch decision |

## Verification
The assertions are evaluated on every cycle. They cover the update rules: full load, carry-only load and hold. They also check that `taken` drops when no branch is requested, that always and never give fixed results, and that the equal code follows the stored zero bit from the cycle before. The bench covers the whole condition table, every flag pattern against every code, including the complement pairing, which only such an exhaustive sweep can show. It also runs directed cases in which a branch and an update meet in the same cycle, to show that the decision uses the pre-update flags.

// File: rtl/cflag_pkg.sv
package cflag_pkg;
  localparam int FLAG_W = 4;
  localparam int COND_W = 4;

  // Bit positions inside the flag vector.
  localparam int FB_N = 3;
  localparam int FB_Z = 2;
  localparam int FB_V = 1;
  localparam int FB_C = 0;

  // Condition codes. Bit 0 set selects the complement of the even code.
  typedef enum logic [COND_W-1:0] {
    CC_ALWAYS = 4'd0,  CC_NEVER = 4'd1,
    CC_EQ     = 4'd2,  CC_NE    = 4'd3,
    CC_SGT    = 4'd4,  CC_SLE   = 4'd5,
    CC_SGE    = 4'd6,  CC_SLT   = 4'd7,
    CC_UGT    = 4'd8,  CC_ULE   = 4'd9,
    CC_CCLR   = 4'd10, CC_CSET  = 4'd11,
    CC_POS    = 4'd12, CC_NEG   = 4'd13,
    CC_VCLR   = 4'd14, CC_VSET  = 4'd15
  } cond_e;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } flags_t;
endpackage

// File: rtl/cflag_rst_sync.sv
module cflag_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/cflag_flag_reg.sv
module cflag_flag_reg
  import cflag_pkg::*;
#(
  parameter int WIDTH = FLAG_W,
  parameter int CARRY_BIT = FB_C
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] alu_flags,
  input  logic             upd_all,
  input  logic             upd_carry,
  output logic [WIDTH-1:0] flags_q
);
  logic [WIDTH-1:0] wr_en;
  logic [WIDTH-1:0] flags_d;

  // Per-bit write enables: a full update covers every bit, a shift only carry.
  always_comb begin
    for (int i = 0; i < WIDTH; i++) begin
      wr_en[i] = upd_all | ((i == CARRY_BIT) & upd_carry);
    end
  end

  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    always_comb begin
      flags_d[g] = wr_en[g] ? alu_flags[g] : flags_q[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags_q[g] <= 1'b0;
      else        flags_q[g] <= flags_d[g];
    end
  end
endmodule

// File: rtl/cflag_cond_eval.sv
module cflag_cond_eval
  import cflag_pkg::*;
(
  input  logic [FLAG_W-1:0] flags,
  input  logic [COND_W-1:0] cond,
  output logic              result
);
  flags_t f;
  logic   base;
  logic   sign_ok;

  always_comb begin
    f       = flags_t'(flags);
    sign_ok = ~(f.n ^ f.v);
    // Select the even member of the pair; bit 0 inverts it.
    unique case (cond[COND_W-1:1])
      3'd0:    base = 1'b1;
      3'd1:    base = f.z;
      3'd2:    base = ~f.z & sign_ok;
      3'd3:    base = sign_ok;
      3'd4:    base = ~f.c & ~f.z;
      3'd5:    base = ~f.c;
      3'd6:    base = ~f.n;
      default: base = ~f.v;
    endcase
    result = base ^ cond[0];
  end
endmodule

// File: rtl/cflag_top.sv
module cflag_top
  import cflag_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FLAG_W-1:0] alu_flags,
  input  logic              upd_all,
  input  logic              upd_carry,
  input  logic              br_valid,
  input  logic [COND_W-1:0] br_cond,
  output logic [FLAG_W-1:0] flags,
  output logic              taken
);
  logic rst_sync_n;
  logic cond_true;
  logic taken_d;
  logic taken_q;

  cflag_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  cflag_flag_reg #(.WIDTH(FLAG_W), .CARRY_BIT(FB_C)) u_flags (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .alu_flags (alu_flags),
    .upd_all   (upd_all),
    .upd_carry (upd_carry),
    .flags_q   (flags)
  );

  // Evaluated on the stored flags, so a same-cycle update is not visible.
  cflag_cond_eval u_eval (
    .flags  (flags),
    .cond   (br_cond),
    .result (cond_true)
  );

  always_comb begin
    taken_d = br_valid & cond_true;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) taken_q <= 1'b0;
    else             taken_q <= taken_d;
  end

  assign taken = taken_q;
endmodule

// File: rtl/cflag_chk.sv
module cflag_chk
  import cflag_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [FLAG_W-1:0] alu_flags,
  input logic              upd_all,
  input logic              upd_carry,
  input logic              br_valid,
  input logic [COND_W-1:0] br_cond,
  input logic [FLAG_W-1:0] flags,
  input logic              taken
);
  p_full_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    upd_all |=> flags == $past(alu_flags));

  p_carry_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_carry && !upd_all) |=>
      (flags[FB_C] == $past(alu_flags[FB_C])) &&
      (flags[FLAG_W-1:1] == $past(flags[FLAG_W-1:1])));

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd_all && !upd_carry) |=> $stable(flags));

  p_idle_not_taken_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !br_valid |=> !taken);

  p_always_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (br_valid && br_cond == CC_ALWAYS) |=> taken);

  p_never_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (br_valid && br_cond == CC_NEVER) |=> !taken);

  // R11: the decision follows the zero bit held before the edge.
  p_equal_old_z_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (br_valid && br_cond == CC_EQ) |=> taken == $past(flags[FB_Z]));
endmodule

bind cflag_top cflag_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .alu_flags (alu_flags),
  .upd_all   (upd_all),
  .upd_carry (upd_carry),
  .br_valid  (br_valid),
  .br_cond   (br_cond),
  .flags     (flags),
  .taken     (taken)
);

// File: tb/cflag_tb_top.sv
module cflag_tb_top;
  logic       clk;
  logic       rst_n;
  logic [3:0] alu_flags;
  logic       upd_all;
  logic       upd_carry;
  logic       br_valid;
  logic [3:0] br_cond;
  logic [3:0] flags;
  logic       taken;

  int n_checks = 0;
  int n_errors = 0;

  logic [3:0] model_flags;
  logic [4:0] exp_q[$];
  string      tag_q[$];
  bit         done = 0;

  cflag_top dut_i (
    .clk(clk), .rst_n(rst_n), .alu_flags(alu_flags), .upd_all(upd_all),
    .upd_carry(upd_carry), .br_valid(br_valid), .br_cond(br_cond),
    .flags(flags), .taken(taken)
  );

  initial clk = 0;
  always #10 clk = ~clk;

  // Condition table written from R6..R10, flags as {N,Z,V,C}.
  function automatic logic ref_cond(input logic [3:0] f, input logic [3:0] c);
    logic n, z, v, cy;
    n = f[3]; z = f[2]; v = f[1]; cy = f[0];
    case (c)
      4'd0:  return 1'b1;
      4'd1:  return 1'b0;
      4'd2:  return z;
      4'd3:  return !z;
      4'd4:  return !z && (n == v);
      4'd5:  return z || (n != v);
      4'd6:  return n == v;
      4'd7:  return n != v;
      4'd8:  return !cy && !z;
      4'd9:  return cy || z;
      4'd10: return !cy;
      4'd11: return cy;
      4'd12: return !n;
      4'd13: return n;
      4'd14: return !v;
      default: return v;
    endcase
  endfunction

  function automatic string cond_tag(input logic [3:0] c);
    if (c < 2)  return "R6";
    if (c < 4)  return "R7";
    if (c < 8)  return "R8";
    if (c < 12) return "R9";
    return "R10";
  endfunction

  // Driver: one cycle of stimulus, expected result pushed to the scoreboard.
  task automatic drive(input logic [3:0] af, input logic ua, input logic uc,
                       input logic bv, input logic [3:0] bc, input string tag);
    logic exp_t;
    @(negedge clk);
    alu_flags = af; upd_all = ua; upd_carry = uc; br_valid = bv; br_cond = bc;
    exp_t = bv && ref_cond(model_flags, bc);
    if (ua)      model_flags = af;
    else if (uc) model_flags[0] = af[0];
    exp_q.push_back({model_flags, exp_t});
    tag_q.push_back(tag);
  endtask

  // Monitor: compares after each rising edge.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        logic [4:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        n_checks++;
        if ({flags, taken} !== e) begin
          n_errors++;
          $display("FAIL %s: flags=%b taken=%b expected flags=%b taken=%b",
                   t, flags, taken, e[4:1], e[0]);
        end
      end
    end
  end

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        n_errors++;
        n_checks++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
      end
    end
  end

  initial begin
    rst_n = 0; alu_flags = 4'hF; upd_all = 1; upd_carry = 1;
    br_valid = 1; br_cond = 4'd0; model_flags = 4'h0;
    repeat (3) @(posedge clk);
    #5;
    n_checks++;
    if (flags !== 4'b0000 || taken !== 1'b0) begin
      n_errors++;
      $display("FAIL R1: flags=%b taken=%b expected flags=0000 taken=0", flags, taken);
    end
    @(negedge clk);
    upd_all = 0; upd_carry = 0; br_valid = 0;
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R2 and R4: load, then hold against changing ALU flags.
    drive(4'b1010, 1, 0, 0, 4'd0, "R2");
    drive(4'b0101, 0, 0, 0, 4'd0, "R4");
    drive(4'b1111, 0, 0, 0, 4'd0, "R4");
    // R3: carry only.
    drive(4'b0001, 0, 1, 0, 4'd0, "R3");
    drive(4'b1110, 0, 1, 0, 4'd0, "R3");
    drive(4'b0111, 1, 1, 0, 4'd0, "R2");
    // R5: condition ignored without a branch strobe.
    for (int c = 0; c < 16; c++) drive(4'b0000, 0, 0, 0, c[3:0], "R5");

    // Full sweep: every flag pattern against every code (R6..R10, R12).
    for (int f = 0; f < 16; f++) begin
      drive(f[3:0], 1, 0, 0, 4'd0, "R2");
      for (int c = 0; c < 16; c += 2) begin
        drive(4'b0000, 0, 0, 1, c[3:0], cond_tag(c[3:0]));
        drive(4'b0000, 0, 0, 1, c[3:0] + 4'd1, "R12");
      end
    end

    // R11: update and branch in the same cycle.
    drive(4'b0000, 1, 0, 0, 4'd0, "R2");
    drive(4'b0100, 1, 0, 1, 4'd2, "R11");
    drive(4'b0000, 1, 0, 1, 4'd2, "R11");
    drive(4'b0001, 0, 1, 1, 4'd11, "R11");
    drive(4'b0000, 0, 0, 1, 4'd11, "R11");
    drive(4'b0000, 0, 0, 0, 4'd0, "R5");

    repeat (3) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule